// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns host characters into asynchronous serial frames on one output line. A frame has one low start bit, then 1 to 15 data bits sent least significant bit first, then an optional parity bit, then a high stop period. The stop period is programmed in half-bit steps, so it can last one, one and a half or two bit times. An external tick at sixteen times the bit rate paces all bit timing. Changing the tick rate changes the baud rate without stopping the transmitter.

The host writes characters into a single holding register. Whenever the shifter is idle, the holding register moves into the shifter, so the host can queue the next character while the current one is still on the line. A one-clock interrupt pulse marks each move. A write that finds the holding register still occupied is dropped and raises a sticky overflow flag. On request the block sends a break: the line is held low for the length of a full frame, including the stop period, and the break goes out ahead of any queued character.

Top module: `ser_tx`

## Requirements
- R1: After reset the line is high, `holdEmpty` and `shiftEmpty` are 1, and `txEmptyIrq` and `wrOverflow` are 0. The line stays high whenever no frame is in progress.
- R2: A frame starts with one low start bit of 16 ticks. It is followed by the data bits, least significant first, 16 ticks each, and no timer advances without `tick16`. `cfgDataBits` selects 1 to 15 bits. A value of 0 gives 1 bit, and with parity enabled a value of 15 is sent as 14 bits. Data bits above the selected length are not sent.
- R3: `cfgParity` encoding: 0 none, 1 even (total count of ones including parity is even), 2 odd, 3 always 1, 4 always 0, and 5 to 7 behave as none. The parity bit lasts 16 ticks and directly follows the last data bit.
- R4: The stop period is high for `cfgHalfStops` × 8 ticks, where 2, 3 or 4 are legal, values below 2 act as 2 and values above 4 act as 4. `shiftEmpty` rises exactly when the stop period ends.
- R5: Length, parity mode and stop setting are captured when a frame starts. Changing the configuration inputs during a frame does not affect that frame, but it applies to the next one.
- R6: A write while `holdEmpty` is 1 is stored, and `holdEmpty` drops on the next clock. A stored character moves to the shifter as soon as the shifter is idle, and `holdEmpty` returns to 1 at that point.
- R7: `txEmptyIrq` is high for exactly one clock. That clock is the first cycle of the start bit of a character taken from the holding register.
- R8: A write while the holding register is full is ignored and sets `wrOverflow`, which stays set until reset. A write in the same cycle as the holding-to-shifter move is accepted and does not set the flag.
- R9: A `brkReq` pulse makes the next frame a break. The line is low for 16 × (1 + data bits + parity bit) + 8 × half stops ticks, using the captured configuration. A break frame goes out before a character that is already queued, and it raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-clock pulse at 16× the bit rate |
| cfgDataBits | input | 4 | Data bits per frame |
| cfgParity | input | 3 | Parity mode |
| cfgHalfStops | input | 3 | Stop period in half bits |
| wrEn | input | 1 | Host write strobe |
| wrData | input | 15 | Host character |
| brkReq | input | 1 | Break request pulse |
| txLine | output | 1 | Serial output, idle high |
| holdEmpty | output | 1 | Holding register free |
| shiftEmpty | output | 1 | No frame in progress |
| txEmptyIrq | output | 1 | Holding-to-shifter move pulse |
| wrOverflow | output | 1 | Sticky dropped-write flag |

## Verification
A host write and the transfer from the holding register to the shifter can land in the same clock. The bench provokes this by queuing a second character during a frame and then writing a third in the first cycle in which `shiftEmpty` is seen high. In that cycle the queued character is being handed to the shifter. The bench judges the result from the ports. `wrOverflow` must stay 0 and `holdEmpty` must stay 0. Both later frames must then decode to the second and third characters, in that order.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_DATA  = 3'd2,
    PH_PAR   = 3'd3,
    PH_STOP  = 3'd4
  } txPhase_e;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_EVEN  = 3'd1,
    PAR_ODD   = 3'd2,
    PAR_ONE   = 3'd3,
    PAR_ZERO  = 3'd4
  } parMode_e;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic     load;   // holding register moves into the shifter
    logic     shift;  // advance to the next data bit
    logic     brk;    // current frame is a break
    txPhase_e phase;
  } txCtl_t;

endpackage

// File: rtl/ser_tx_ctrl.sv
module ser_tx_ctrl
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 15,
  parameter int OSR    = 16,
  localparam int NB_W  = $clog2(DATA_W + 1),
  localparam int HALF  = OSR / 2,
  localparam int CNT_W = $clog2(2 * OSR)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tick16,
  input  logic            brkReq,
  input  logic            holdFull,
  input  logic [NB_W-1:0] cfgDataBits,
  input  logic [2:0]      cfgParity,
  input  logic [2:0]      cfgHalfStops,
  output logic [NB_W-1:0] loadBits,
  output txCtl_t          ctl,
  output logic            shiftEmpty
);

  txPhase_e        phase;
  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lenM1;
  logic [NB_W-1:0]  bitsLeft;
  logic             parQ;
  logic [2:0]       hsQ;
  logic             brkQ;
  logic             brkPend;

  logic             parOnIn;
  logic [NB_W-1:0]  effBits;
  logic [2:0]       effHs;
  logic             startBrk;
  logic             startChr;
  logic             phaseEnd;

  // configuration sanitising, sampled only at frame start
  always_comb begin
    parOnIn = (cfgParity != 3'd0) && (cfgParity <= 3'd4);
    effBits = cfgDataBits;
    if (effBits == '0) effBits = NB_W'(1);
    if (effBits >= NB_W'(DATA_W))
      effBits = parOnIn ? NB_W'(DATA_W - 1) : NB_W'(DATA_W);
    effHs = cfgHalfStops;
    if (effHs < 3'd2) effHs = 3'd2;
    if (effHs > 3'd4) effHs = 3'd4;
  end

  assign loadBits = effBits;

  // a pending break wins over a queued character
  assign startBrk = (phase == PH_IDLE) && brkPend;
  assign startChr = (phase == PH_IDLE) && !brkPend && holdFull;

  always_comb begin
    if (phase == PH_STOP) lenM1 = CNT_W'(hsQ) * CNT_W'(HALF) - CNT_W'(1);
    else                  lenM1 = CNT_W'(OSR - 1);
  end

  assign phaseEnd = tick16 && (phase != PH_IDLE) && (tickCnt == lenM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      tickCnt  <= '0;
      bitsLeft <= '0;
      parQ     <= 1'b0;
      hsQ      <= 3'd2;
      brkQ     <= 1'b0;
      brkPend  <= 1'b0;
    end else begin
      if (startBrk)    brkPend <= 1'b0;
      else if (brkReq) brkPend <= 1'b1;

      if (phase == PH_IDLE) begin
        if (startBrk || startChr) begin
          phase    <= PH_START;
          tickCnt  <= '0;
          bitsLeft <= effBits;
          parQ     <= parOnIn;
          hsQ      <= effHs;
          brkQ     <= startBrk;
        end
      end else if (tick16) begin
        if (tickCnt == lenM1) begin
          tickCnt <= '0;
          case (phase)
            PH_START: phase <= PH_DATA;
            PH_DATA: begin
              if (bitsLeft == NB_W'(1)) phase <= parQ ? PH_PAR : PH_STOP;
              else                      bitsLeft <= bitsLeft - 1'b1;
            end
            PH_PAR:  phase <= PH_STOP;
            default: phase <= PH_IDLE;
          endcase
        end else begin
          tickCnt <= tickCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctl.load   = startChr;
    ctl.shift  = phaseEnd && (phase == PH_DATA);
    ctl.brk    = brkQ;
    ctl.phase  = phase;
  end

  assign shiftEmpty = (phase == PH_IDLE);

  // R2: bit timers only move on a tick
  p_tick_pace_r2: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && !tick16) |=> $stable(tickCnt));

  // R5: captured frame settings hold for the whole frame
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |->
      ($stable(hsQ) && $stable(parQ) && $stable(brkQ)));

  // R9: a break request is consumed by a break frame start
  p_break_taken_r9: assert property (@(posedge clk) disable iff (!rstN)
    (brkPend && phase == PH_IDLE) |=> (phase == PH_START && brkQ));

endmodule

// File: rtl/ser_tx_dp.sv
module ser_tx_dp
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 15,
  localparam int NB_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NB_W-1:0]   loadBits,
  input  logic [2:0]        loadParMode,
  input  txCtl_t            ctl,
  output logic              holdFull,
  output logic              txLine,
  output logic              txEmptyIrq,
  output logic              wrOverflow
);

  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] masked;
  logic              parQ;
  logic              parCalc;
  logic              accept;
  logic              irqQ;
  logic              ovfQ;

  // keep only the selected number of low data bits
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
    assign mask[gi] = (NB_W'(gi) < loadBits);
  end
  assign masked = holdData & mask;

  always_comb begin
    case (loadParMode)
      PAR_EVEN: parCalc = ^masked;
      PAR_ODD:  parCalc = ~^masked;
      PAR_ONE:  parCalc = 1'b1;
      default:  parCalc = 1'b0;
    endcase
  end

  // a write is taken if the holder is free or is being emptied this cycle
  assign accept = wrEn && (!holdFull || ctl.load);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdFull <= 1'b0;
      holdData <= '0;
      shReg    <= '0;
      parQ     <= 1'b0;
      irqQ     <= 1'b0;
      ovfQ     <= 1'b0;
    end else begin
      if (ctl.load)    holdFull <= accept;
      else if (accept) holdFull <= 1'b1;
      if (accept) holdData <= wrData;
      if (wrEn && holdFull && !ctl.load) ovfQ <= 1'b1;
      irqQ <= ctl.load;
      if (ctl.load) begin
        shReg <= masked;
        parQ  <= parCalc;
      end else if (ctl.shift) begin
        shReg <= shReg >> 1;
      end
    end
  end

  always_comb begin
    case (ctl.phase)
      PH_START: txLine = 1'b0;
      PH_DATA:  txLine = shReg[0] & ~ctl.brk;
      PH_PAR:   txLine = parQ & ~ctl.brk;
      PH_STOP:  txLine = ~ctl.brk;
      default:  txLine = 1'b1;
    endcase
  end

  assign txEmptyIrq = irqQ;
  assign wrOverflow = ovfQ;

  // R6: a write into a free holder fills it
  p_hold_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !holdFull) |=> holdFull);

  // R7: interrupt is a single clock wide
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyIrq |=> !txEmptyIrq);

  // R7: interrupt lines up with a start bit on the line
  p_irq_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    txEmptyIrq |-> (ctl.phase == PH_START && !txLine));

  // R8: overflow flag never clears outside reset
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrOverflow |=> wrOverflow);

  // R9: break frames raise no interrupt
  p_break_no_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.brk && ctl.phase != PH_IDLE) |-> !txEmptyIrq);

endmodule

// File: rtl/ser_tx.sv
module ser_tx
  import ser_tx_pkg::*;
#(
  parameter int DATA_W = 15,
  parameter int OSR    = 16,
  localparam int NB_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic [NB_W-1:0]   cfgDataBits,
  input  logic [2:0]        cfgParity,
  input  logic [2:0]        cfgHalfStops,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              brkReq,
  output logic              txLine,
  output logic              holdEmpty,
  output logic              shiftEmpty,
  output logic              txEmptyIrq,
  output logic              wrOverflow
);

  txCtl_t          ctl;
  logic            holdFull;
  logic [NB_W-1:0] loadBits;

  ser_tx_ctrl #(.DATA_W(DATA_W), .OSR(OSR)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .tick16       (tick16),
    .brkReq       (brkReq),
    .holdFull     (holdFull),
    .cfgDataBits  (cfgDataBits),
    .cfgParity    (cfgParity),
    .cfgHalfStops (cfgHalfStops),
    .loadBits     (loadBits),
    .ctl          (ctl),
    .shiftEmpty   (shiftEmpty)
  );

  ser_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .loadBits    (loadBits),
    .loadParMode (cfgParity),
    .ctl         (ctl),
    .holdFull    (holdFull),
    .txLine      (txLine),
    .txEmptyIrq  (txEmptyIrq),
    .wrOverflow  (wrOverflow)
  );

  assign holdEmpty = !holdFull;

endmodule

// File: tb/ser_tx_bench.sv
`timescale 1ns/1ps
module ser_tx_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick16 = 1'b0;
  logic [3:0]  cfgDataBits = 4'd8;
  logic [2:0]  cfgParity = 3'd0;
  logic [2:0]  cfgHalfStops = 3'd2;
  logic        wrEn = 1'b0;
  logic [14:0] wrData = '0;
  logic        brkReq = 1'b0;
  logic        txLine, holdEmpty, shiftEmpty, txEmptyIrq, wrOverflow;

  int checks = 0;
  int errors = 0;
  int tickCount = 0;
  int tickDiv = 0;

  always #5 clk = ~clk;

  ser_tx u_ser_tx (
    .clk(clk), .rstN(rstN), .tick16(tick16),
    .cfgDataBits(cfgDataBits), .cfgParity(cfgParity), .cfgHalfStops(cfgHalfStops),
    .wrEn(wrEn), .wrData(wrData), .brkReq(brkReq),
    .txLine(txLine), .holdEmpty(holdEmpty), .shiftEmpty(shiftEmpty),
    .txEmptyIrq(txEmptyIrq), .wrOverflow(wrOverflow)
  );

  // tick every fourth clock, driven away from the sampling edge
  always @(negedge clk) begin
    tickDiv = (tickDiv == 3) ? 0 : tickDiv + 1;
    tick16 = (tickDiv == 0);
  end
  always @(posedge clk) if (tick16) tickCount <= tickCount + 1;

  // {data[14:0], bits[3:0], parity[2:0], halfStops[2:0]}
  localparam logic [24:0] VEC [8] = '{
    {15'h0055, 4'd8,  3'd0, 3'd2},
    {15'h00A5, 4'd8,  3'd1, 3'd2},
    {15'h00A4, 4'd8,  3'd2, 3'd3},
    {15'h7FFF, 4'd15, 3'd0, 3'd4},
    {15'h0001, 4'd1,  3'd3, 3'd2},
    {15'h2AAA, 4'd14, 3'd4, 3'd3},
    {15'h7ABC, 4'd5,  3'd1, 3'd4},
    {15'h4321, 4'd15, 3'd2, 3'd2}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic setCfg(input int nb, input int pm, input int hs);
    cfgDataBits = 4'(nb);
    cfgParity = 3'(pm);
    cfgHalfStops = 3'(hs);
  endtask

  task automatic writeChar(input int d);
    wrData = 15'(d);
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseBreak();
    brkReq = 1'b1;
    @(negedge clk);
    brkReq = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    wrEn = 1'b0;
    brkReq = 1'b0;
    repeat (3) @(negedge clk);
    chk(txLine == 1'b1 && holdEmpty && shiftEmpty && !txEmptyIrq && !wrOverflow,
        "R1", "reset outputs {line,holdE,shE,irq,ovf}",
        {txLine, holdEmpty, shiftEmpty, txEmptyIrq, wrOverflow}, 5'b11100);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitTick(input int t);
    while (tickCount < t) @(negedge clk);
  endtask

  function automatic int effBits(input int nb, input int pm);
    bit pOn = (pm >= 1 && pm <= 4);
    int n = (nb == 0) ? 1 : nb;
    if (n >= 15) n = pOn ? 14 : 15;
    return n;
  endfunction

  function automatic int effHs(input int hs);
    return (hs < 2) ? 2 : ((hs > 4) ? 4 : hs);
  endfunction

  function automatic bit expPar(input int d, input int n, input int pm);
    int m = d & ((1 << n) - 1);
    int ones = $countones(m);
    case (pm)
      1: return bit'(ones % 2);
      2: return !bit'(ones % 2);
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // decodes one frame from its falling edge; tag names the requirement for data
  task automatic checkFrame(input int d, input int nb, input int pm, input int hs,
                            input bit brk, input bit doSwap);
    int n = effBits(nb, pm);
    int p = (pm >= 1 && pm <= 4) ? 1 : 0;
    int frameTicks = 16 * (1 + n + p) + 8 * effHs(hs);
    int t0;
    int rx = 0;
    int expData = brk ? 0 : (d & ((1 << n) - 1));
    string tag = brk ? "R9" : "R2";
    while (txLine) @(negedge clk);
    t0 = tickCount;
    if (doSwap) setCfg(5, 2, 4);
    waitTick(t0 + 8);
    chk(txLine == 1'b0, "R2", "start bit level", txLine, 0);
    for (int k = 0; k < n; k++) begin
      waitTick(t0 + 16 * (k + 1) + 8);
      rx = rx | (int'(txLine) << k);
    end
    chk(rx == expData, tag, "data bits", rx, expData);
    if (p == 1) begin
      waitTick(t0 + 16 * (1 + n) + 8);
      chk(txLine == (brk ? 1'b0 : expPar(d, n, pm)), brk ? "R9" : "R3",
          "parity bit", txLine, brk ? 0 : int'(expPar(d, n, pm)));
    end
    waitTick(t0 + 16 * (1 + n + p) + 4);
    chk(txLine == !brk, brk ? "R9" : "R4", "stop level", txLine, int'(!brk));
    while (!shiftEmpty) @(negedge clk);
    chk(tickCount - t0 == frameTicks, brk ? "R9" : "R4", "frame length in ticks",
        tickCount - t0, frameTicks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    doReset();

    // table walk: R2, R3, R4 over lengths, parity modes, stop lengths
    for (int i = 0; i < 8; i++) begin
      setCfg(int'(VEC[i][9:6]), int'(VEC[i][5:3]), int'(VEC[i][2:0]));
      writeChar(int'(VEC[i][24:10]));
      checkFrame(int'(VEC[i][24:10]), int'(VEC[i][9:6]), int'(VEC[i][5:3]),
                 int'(VEC[i][2:0]), 1'b0, 1'b0);
    end

    // R4: out-of-range stop setting acts as the nearest legal one
    setCfg(3, 0, 7);
    writeChar(5);
    checkFrame(5, 3, 0, 7, 1'b0, 1'b0);

    // R6, R7: write into idle block, pulse timing
    setCfg(8, 0, 2);
    writeChar(8'h3C);
    chk(!holdEmpty && !txEmptyIrq && txLine, "R6", "holder filled, no frame yet",
        {holdEmpty, txEmptyIrq, txLine}, 3'b001);
    @(negedge clk);
    chk(txEmptyIrq && holdEmpty && !txLine, "R7", "irq with start bit, holder freed",
        {txEmptyIrq, holdEmpty, txLine}, 3'b110);
    @(negedge clk);
    chk(!txEmptyIrq, "R7", "irq one clock wide", txEmptyIrq, 0);
    while (!shiftEmpty) @(negedge clk);

    // R8: write into full holder is dropped and sticky
    writeChar(8'h11);
    fork
      checkFrame(8'h11, 8, 0, 2, 1'b0, 1'b0);
      begin
        repeat (20) @(negedge clk);
        writeChar(8'h22);
        chk(!holdEmpty && !wrOverflow, "R6", "queued write accepted",
            {holdEmpty, wrOverflow}, 0);
        writeChar(8'h33);
        chk(wrOverflow && !holdEmpty, "R8", "overflow on full holder",
            {wrOverflow, holdEmpty}, 2'b10);
      end
    join
    checkFrame(8'h22, 8, 0, 2, 1'b0, 1'b0);
    repeat (300) @(negedge clk);
    chk(txLine && shiftEmpty && holdEmpty && wrOverflow, "R8",
        "dropped char never sent, flag sticky",
        {txLine, shiftEmpty, holdEmpty, wrOverflow}, 4'b1111);

    // R8: write coinciding with holder-to-shifter move
    doReset();
    setCfg(8, 0, 2);
    writeChar(8'h5A);
    fork
      checkFrame(8'h5A, 8, 0, 2, 1'b0, 1'b0);
      begin
        repeat (20) @(negedge clk);
        writeChar(8'hC3);
      end
    join
    writeChar(8'h69);
    chk(!holdEmpty && !wrOverflow && !txLine, "R8", "same-cycle write accepted",
        {holdEmpty, wrOverflow, txLine}, 0);
    checkFrame(8'hC3, 8, 0, 2, 1'b0, 1'b0);
    checkFrame(8'h69, 8, 0, 2, 1'b0, 1'b0);
    chk(holdEmpty && !wrOverflow, "R8", "queue drained without overflow",
        {holdEmpty, wrOverflow}, 2'b10);

    // R5: configuration change mid-frame ignored, then applied
    setCfg(8, 0, 2);
    writeChar(8'h96);
    checkFrame(8'h96, 8, 0, 2, 1'b0, 1'b1);
    writeChar(8'h13);
    checkFrame(8'h13, 5, 2, 4, 1'b0, 1'b0);

    // R9: break ahead of queued char
    setCfg(8, 1, 3);
    writeChar(8'h81);
    fork
      checkFrame(8'h81, 8, 1, 3, 1'b0, 1'b0);
      begin
        repeat (20) @(negedge clk);
        writeChar(8'h7E);
        pulseBreak();
      end
    join
    @(negedge clk);
    chk(!txLine && !holdEmpty && !txEmptyIrq, "R9", "break first, char still queued, no irq",
        {txLine, holdEmpty, txEmptyIrq}, 0);
    checkFrame(0, 8, 1, 3, 1'b1, 1'b0);
    checkFrame(8'h7E, 8, 1, 3, 1'b0, 1'b0);

    // R9: break from idle
    setCfg(5, 0, 2);
    pulseBreak();
    checkFrame(0, 5, 0, 2, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk(txLine && shiftEmpty, "R1", "line back to idle high", {txLine, shiftEmpty}, 2'b11);

    summary();
    $finish;
  end

endmodule